// File: doc/BRIEF.md
# Sigma-Delta Converter Diagnostic Monitor

This block sits beside the digital back end of a sigma-delta converter and watches it for faults. It samples the single-bit modulator stream, the offset coefficient delivered at the end of an offset calibration, the overflow indication of the decimation filter during a full-scale calibration, and the filtered conversion results taken while the sensor leads are under burnout test.

Each fault class owns one sticky bit in an error register. Software reads the register through a small register port and clears bits by writing ones to them. A mask register hides chosen classes from the combined error output. A margin register sets how close to the top code a lead-test reading must be to count as an open lead.

Top module: `sdm_diag_monitor`

## Requirements
- R1: The saturation flag (error bit 0) sets in the clock edge at which the modulator presents its 20th identical consecutive valid bit. All ones and all zeros both count.
- R2: A valid bit that differs from the previous valid bit restarts the run at one. Cycles without a valid strobe neither count nor break a run. The run count saturates, so an unbroken run of any length keeps raising the flag on each further identical bit.
- R3: When offset calibration completes, the calibration range flag (error bit 1) sets if the coefficient is below 0x07FFFF or above 0xF80000. Both limits are accepted.
- R4: The filter overflow flag (error bit 2) sets only when the overflow indication and the full-scale calibration indication are high together.
- R5: With lead test enabled, a valid result at or above 0xFFFFFF minus the margin register sets the open-lead flag (error bit 3). The margin register is at address 2 and resets to 16.
- R6: With lead test enabled, a valid result of zero sets the shorted-lead flag (error bit 4).
- R7: Results presented while lead test is disabled set neither lead flag.
- R8: The error register reads at address 0 with bits 4..0 as listed above and upper bits zero. It is zero after reset.
- R9: Error bits are sticky. A write to address 0 clears each bit written as 1. An event in the same cycle as its clear leaves the bit set.
- R10: The mask register is at address 1 and resets to zero; a 1 masks that error bit. `err_any` is high exactly when some unmasked error bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_bit | input | 1 | Modulator output bit |
| mod_vld | input | 1 | Strobe qualifying mod_bit |
| cal_done | input | 1 | Offset calibration finished this cycle |
| cal_coef | input | 24 | Offset coefficient from that calibration |
| fs_cal_active | input | 1 | Full-scale calibration in progress |
| filt_ovf | input | 1 | Decimation filter overflow |
| res_vld | input | 1 | Conversion result valid |
| res_data | input | 24 | Filtered conversion result |
| lead_test_en | input | 1 | Burnout lead test enabled |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data for reg_addr |
| err_any | output | 1 | Any unmasked error set |

## Verification
The critical overlap is between a write-one-to-clear of the error register and a fresh fault event on the same bit in the same cycle. The bench provokes it directly by holding a saturated modulator run and issuing the clear on the next identical bit. The random phase repeats the overlap with clears at random moments while random faults arrive. A bench model that applies the clear first and then ORs in the events judges each case: the bit must read back as set, and `err_any` must follow.

// File: rtl/sdm_diag_pkg.sv
`timescale 1ns/1ps
package sdm_diag_pkg;
   localparam int NUM_FLAGS = 5;
   localparam int FLG_SAT   = 0;
   localparam int FLG_CAL   = 1;
   localparam int FLG_OVF   = 2;
   localparam int FLG_OPEN  = 3;
   localparam int FLG_SHORT = 4;

   typedef logic [NUM_FLAGS-1:0] flag_vec_t;

   localparam logic [1:0] ADDR_ERR    = 2'd0;
   localparam logic [1:0] ADDR_MASK   = 2'd1;
   localparam logic [1:0] ADDR_MARGIN = 2'd2;
endpackage

// File: rtl/sdm_run_detector.sv
`timescale 1ns/1ps
module sdm_run_detector #(
   parameter int RUN_LEN = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_in,
   input  logic bit_vld,
   output logic sat_evt
);
   localparam int CW = $clog2(RUN_LEN + 1);
   localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);
   localparam logic [CW-1:0] ONE   = CW'(1);

   generate
      if (RUN_LEN < 2) begin : g_bad_len
         $error("sdm_run_detector: RUN_LEN must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q, cnt_d;
   logic          prev_q;
   logic          have_q;

   always_comb begin
      cnt_d = cnt_q;
      if (bit_vld) begin
         if (have_q && (bit_in == prev_q)) begin
            cnt_d = (cnt_q == LIMIT) ? cnt_q : cnt_q + ONE;
         end else begin
            cnt_d = ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         prev_q <= 1'b0;
         have_q <= 1'b0;
      end else if (bit_vld) begin
         cnt_q  <= cnt_d;
         prev_q <= bit_in;
         have_q <= 1'b1;
      end
   end

   assign sat_evt = bit_vld && (cnt_d == LIMIT);
endmodule

// File: rtl/sdm_cal_window.sv
`timescale 1ns/1ps
module sdm_cal_window #(
   parameter int              W  = 24,
   parameter logic [W-1:0]    LO = 24'h07FFFF,
   parameter logic [W-1:0]    HI = 24'hF80000
) (
   input  logic         done,
   input  logic [W-1:0] coef,
   output logic         range_evt
);
   logic below, above;

   generate
      if (LO > HI) begin : g_bad_win
         $error("sdm_cal_window: LO exceeds HI");
      end
      if (LO == '0) begin : g_no_lo
         assign below = 1'b0;
      end else begin : g_lo
         assign below = (coef < LO);
      end
      if (HI == '1) begin : g_no_hi
         assign above = 1'b0;
      end else begin : g_hi
         assign above = (coef > HI);
      end
   endgenerate

   assign range_evt = done && (below || above);
endmodule

// File: rtl/sdm_lead_classifier.sv
`timescale 1ns/1ps
module sdm_lead_classifier #(
   parameter int W = 24
) (
   input  logic         res_vld,
   input  logic         test_en,
   input  logic [W-1:0] res,
   input  logic [W-1:0] margin,
   output logic         open_evt,
   output logic         short_evt
);
   localparam logic [W:0] TOP = {1'b0, {W{1'b1}}};

   logic [W:0] reach;
   logic       qual;

   assign qual      = res_vld && test_en;
   assign reach     = {1'b0, res} + {1'b0, margin};
   assign open_evt  = qual && (reach >= TOP);
   assign short_evt = qual && (res == '0);
endmodule

// File: rtl/sdm_err_regs.sv
`timescale 1ns/1ps
module sdm_err_regs
   import sdm_diag_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  flag_vec_t evt,
   input  flag_vec_t clr,
   input  logic      mask_wr,
   input  flag_vec_t mask_d,
   output flag_vec_t err_q,
   output flag_vec_t mask_q,
   output logic      err_any
);
   generate
      for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               err_q[i] <= 1'b0;
            end else begin
               err_q[i] <= (err_q[i] && !clr[i]) || evt[i];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (mask_wr) begin
         mask_q <= mask_d;
      end
   end

   assign err_any = |(err_q & ~mask_q);
endmodule

// File: rtl/sdm_diag_monitor.sv
`timescale 1ns/1ps
module sdm_diag_monitor
   import sdm_diag_pkg::*;
#(
   parameter int                 DATA_W     = 24,
   parameter int                 RUN_LEN    = 20,
   parameter logic [DATA_W-1:0]  CAL_LO     = 24'h07FFFF,
   parameter logic [DATA_W-1:0]  CAL_HI     = 24'hF80000,
   parameter logic [DATA_W-1:0]  MARGIN_DEF = 24'd16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_bit,
   input  logic              mod_vld,
   input  logic              cal_done,
   input  logic [DATA_W-1:0] cal_coef,
   input  logic              fs_cal_active,
   input  logic              filt_ovf,
   input  logic              res_vld,
   input  logic [DATA_W-1:0] res_data,
   input  logic              lead_test_en,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              err_any
);
   generate
      if (DATA_W < NUM_FLAGS) begin : g_bad_w
         $error("sdm_diag_monitor: DATA_W narrower than the error field");
      end
   endgenerate

   flag_vec_t         evt, clr, err_q, mask_q;
   logic [DATA_W-1:0] margin_q;
   logic              wr_err, wr_mask, wr_margin;

   assign wr_err    = reg_wr && (reg_addr == ADDR_ERR);
   assign wr_mask   = reg_wr && (reg_addr == ADDR_MASK);
   assign wr_margin = reg_wr && (reg_addr == ADDR_MARGIN);
   assign clr       = wr_err ? reg_wdata[NUM_FLAGS-1:0] : '0;

   sdm_run_detector #(.RUN_LEN(RUN_LEN)) i_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_in  (mod_bit),
      .bit_vld (mod_vld),
      .sat_evt (evt[FLG_SAT])
   );

   sdm_cal_window #(.W(DATA_W), .LO(CAL_LO), .HI(CAL_HI)) i_cal (
      .done      (cal_done),
      .coef      (cal_coef),
      .range_evt (evt[FLG_CAL])
   );

   assign evt[FLG_OVF] = fs_cal_active && filt_ovf;

   sdm_lead_classifier #(.W(DATA_W)) i_lead (
      .res_vld   (res_vld),
      .test_en   (lead_test_en),
      .res       (res_data),
      .margin    (margin_q),
      .open_evt  (evt[FLG_OPEN]),
      .short_evt (evt[FLG_SHORT])
   );

   sdm_err_regs i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .clr     (clr),
      .mask_wr (wr_mask),
      .mask_d  (reg_wdata[NUM_FLAGS-1:0]),
      .err_q   (err_q),
      .mask_q  (mask_q),
      .err_any (err_any)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         margin_q <= MARGIN_DEF;
      end else if (wr_margin) begin
         margin_q <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_ERR:    reg_rdata[NUM_FLAGS-1:0] = err_q;
         ADDR_MASK:   reg_rdata[NUM_FLAGS-1:0] = mask_q;
         ADDR_MARGIN: reg_rdata = margin_q;
         default:     reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sdm_diag_checker.sv
`timescale 1ns/1ps
module sdm_diag_checker
   import sdm_diag_pkg::*;
#(
   parameter int DATA_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mod_vld,
   input logic              cal_done,
   input logic              fs_cal_active,
   input logic              filt_ovf,
   input logic              res_vld,
   input logic [DATA_W-1:0] res_data,
   input logic              lead_test_en,
   input logic              reg_wr,
   input logic [1:0]        reg_addr,
   input flag_vec_t         clr_bits,
   input flag_vec_t         err_q,
   input logic              err_any
);
   flag_vec_t clr_w;
   assign clr_w = (reg_wr && reg_addr == ADDR_ERR) ? clr_bits : '0;

   // R1
   sat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q[FLG_SAT]) |-> $past(mod_vld));

   // R3
   cal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q[FLG_CAL]) |-> $past(cal_done));

   // R4
   ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q[FLG_OVF]) |-> $past(fs_cal_active && filt_ovf));

   // R7
   lead_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(err_q[FLG_OPEN]) || $rose(err_q[FLG_SHORT])) |-> $past(res_vld && lead_test_en));

   // R6
   short_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && lead_test_en && res_data == '0) |=> err_q[FLG_SHORT]);

   // R9
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(err_q) & ~$past(clr_w)) & ~err_q) == '0));

   // R10
   any_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_any |-> (err_q != '0));
endmodule

bind sdm_diag_monitor sdm_diag_checker #(.DATA_W(DATA_W)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mod_vld       (mod_vld),
   .cal_done      (cal_done),
   .fs_cal_active (fs_cal_active),
   .filt_ovf      (filt_ovf),
   .res_vld       (res_vld),
   .res_data      (res_data),
   .lead_test_en  (lead_test_en),
   .reg_wr        (reg_wr),
   .reg_addr      (reg_addr),
   .clr_bits      (reg_wdata[sdm_diag_pkg::NUM_FLAGS-1:0]),
   .err_q         (err_q),
   .err_any       (err_any)
);

// File: tb/test_sdm_diag_monitor.sv
`timescale 1ns/1ps
module test_sdm_diag_monitor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mod_bit = 1'b0, mod_vld = 1'b0;
   logic        cal_done = 1'b0;
   logic [23:0] cal_coef = '0;
   logic        fs_cal_active = 1'b0, filt_ovf = 1'b0;
   logic        res_vld = 1'b0, lead_test_en = 1'b0;
   logic [23:0] res_data = '0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [23:0] reg_wdata = '0;
   logic [23:0] reg_rdata;
   logic        err_any;

   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;
   logic [4:0]  m_err = '0, m_mask = '0;
   logic [23:0] m_margin = 24'd16;
   int   run = 0;
   logic prev_bit = 1'b0, have_prev = 1'b0;
   string ftag [5] = '{"R1", "R3", "R4", "R5", "R6"};

   always #10 clk = ~clk;

   sdm_diag_monitor i_sdm_diag_monitor (
      .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .mod_vld(mod_vld),
      .cal_done(cal_done), .cal_coef(cal_coef), .fs_cal_active(fs_cal_active),
      .filt_ovf(filt_ovf), .res_vld(res_vld), .res_data(res_data),
      .lead_test_en(lead_test_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_any(err_any)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [4:0] events();
      logic [4:0] e = '0;
      if (mod_vld && run >= 20) e[0] = 1'b1;
      if (cal_done && (cal_coef < 24'h07FFFF || cal_coef > 24'hF80000)) e[1] = 1'b1;
      if (fs_cal_active && filt_ovf) e[2] = 1'b1;
      if (res_vld && lead_test_en) begin
         if ({8'h0, res_data} + {8'h0, m_margin} >= 32'h00FFFFFF) e[3] = 1'b1;
         if (res_data == 24'h0) e[4] = 1'b1;
      end
      return e;
   endfunction

   task automatic cyc();
      logic [4:0] clr;
      @(posedge clk);
      if (mod_vld) begin
         if (have_prev && mod_bit == prev_bit) begin
            if (run < 20) run++;
         end else begin
            run = 1;
         end
         prev_bit = mod_bit;
         have_prev = 1'b1;
      end
      clr = (reg_wr && reg_addr == 2'd0) ? reg_wdata[4:0] : 5'h0;
      m_err = (m_err & ~clr) | events();
      if (reg_wr && reg_addr == 2'd1) m_mask = reg_wdata[4:0];
      if (reg_wr && reg_addr == 2'd2) m_margin = reg_wdata;
      @(negedge clk);
      mod_vld = 1'b0; cal_done = 1'b0; filt_ovf = 1'b0; res_vld = 1'b0;
      reg_wr = 1'b0; reg_addr = 2'd0;
      #1;
      for (int i = 0; i < 5; i++) check(ftag[i], 32'(reg_rdata[i]), 32'(m_err[i]));
      check("R10 err_any", 32'(err_any), 32'(|(m_err & ~m_mask)));
   endtask

   task automatic send_bit(logic b);
      mod_vld = 1'b1; mod_bit = b; cyc();
   endtask

   task automatic wr(logic [1:0] a, logic [23:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; cyc();
   endtask

   task automatic rd(logic [1:0] a, output logic [23:0] d);
      reg_addr = a; #1; d = reg_rdata; reg_addr = 2'd0; #1;
   endtask

   task automatic cal(logic [23:0] c);
      cal_done = 1'b1; cal_coef = c; cyc();
   endtask

   task automatic result(logic [23:0] r);
      res_vld = 1'b1; res_data = r; cyc();
   endtask

   initial begin
      logic [23:0] d;
      logic cur;
      void'($urandom(32'd24680));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1; #1;

      rd(2'd0, d); check("R8 reset err", 32'(d), 0);
      rd(2'd1, d); check("R10 reset mask", 32'(d), 0);
      rd(2'd2, d); check("R5 reset margin", 32'(d), 16);

      // R1/R2: run of ones with invalid gap, 19 then 20
      for (int i = 0; i < 10; i++) send_bit(1'b1);
      repeat (4) cyc();
      for (int i = 0; i < 9; i++) send_bit(1'b1);
      rd(2'd0, d); check("R2 gap no break at 19", 32'(d[0]), 0);
      send_bit(1'b1);
      rd(2'd0, d); check("R1 ones at 20", 32'(d[0]), 1);
      wr(2'd0, 24'h000001);
      rd(2'd0, d); check("R9 w1c clears", 32'(d[0]), 0);

      // R2: differing bit restarts; zeros run
      for (int i = 0; i < 10; i++) send_bit(1'b0);
      send_bit(1'b1);
      for (int i = 0; i < 19; i++) send_bit(1'b0);
      rd(2'd0, d); check("R2 restart no flag", 32'(d[0]), 0);
      send_bit(1'b0);
      rd(2'd0, d); check("R1 zeros at 20", 32'(d[0]), 1);

      // R2 saturation then R9 clear colliding with event
      for (int i = 0; i < 60; i++) send_bit(1'b0);
      wr(2'd0, 24'h000001);
      rd(2'd0, d); check("R2 long run cleared", 32'(d[0]), 0);
      send_bit(1'b0);
      rd(2'd0, d); check("R2 no wrap reraise", 32'(d[0]), 1);
      mod_vld = 1'b1; mod_bit = 1'b0; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 24'h1F; cyc();
      rd(2'd0, d); check("R9 event wins clear", 32'(d[0]), 1);
      wr(2'd0, 24'hFFFFFF);

      // R3 window limits
      cal(24'h07FFFF); cal(24'hF80000); cal(24'h400000);
      rd(2'd0, d); check("R3 limits accepted", 32'(d[1]), 0);
      cal(24'h07FFFE);
      rd(2'd0, d); check("R3 below low", 32'(d[1]), 1);
      wr(2'd0, 24'h2);
      cal(24'hF80001);
      rd(2'd0, d); check("R3 above high", 32'(d[1]), 1);

      // R4
      filt_ovf = 1'b1; cyc();
      rd(2'd0, d); check("R4 ovf outside cal", 32'(d[2]), 0);
      fs_cal_active = 1'b1; filt_ovf = 1'b1; cyc(); fs_cal_active = 1'b0;
      rd(2'd0, d); check("R4 ovf in cal", 32'(d[2]), 1);

      // R7 lead test off
      result(24'h000000); result(24'hFFFFFF);
      rd(2'd0, d); check("R7 disabled lead", 32'(d[4:3]), 0);
      lead_test_en = 1'b1;
      result(24'hFFFFFF - 24'd17);
      rd(2'd0, d); check("R5 beyond margin", 32'(d[3]), 0);
      result(24'hFFFFFF - 24'd16);
      rd(2'd0, d); check("R5 at margin", 32'(d[3]), 1);
      result(24'h000001);
      rd(2'd0, d); check("R6 one not short", 32'(d[4]), 0);
      result(24'h000000);
      rd(2'd0, d); check("R6 zero short", 32'(d[4]), 1);
      wr(2'd0, 24'h18); wr(2'd2, 24'd0);
      result(24'hFFFFFE);
      rd(2'd0, d); check("R5 margin zero", 32'(d[3]), 0);
      result(24'hFFFFFF);
      rd(2'd0, d); check("R5 full code", 32'(d[3]), 1);

      // R10 mask
      wr(2'd1, 24'h1F);
      check("R10 all masked", 32'(err_any), 0);
      wr(2'd1, 24'h17);
      check("R10 open unmasked", 32'(err_any), 1);
      rd(2'd0, d); check("R8 upper bits zero", 32'(d[23:5]), 0);
      wr(2'd1, 24'h0); wr(2'd2, 24'd16); wr(2'd0, 24'h1F);

      // random phase
      cur = 1'b0;
      for (int n = 0; n < 4000; n++) begin
         if ($urandom % 100 < 70) begin
            mod_vld = 1'b1;
            if ($urandom % 100 < 10) cur = ~cur;
            mod_bit = cur;
         end
         if ($urandom % 40 == 0) begin
            cal_done = 1'b1;
            case ($urandom % 4)
               0: cal_coef = 24'h07FFFF - 24'($urandom % 3);
               1: cal_coef = 24'hF7FFFF + 24'($urandom % 3);
               2: cal_coef = 24'($urandom);
               default: cal_coef = 24'h800000;
            endcase
         end
         if ($urandom % 50 == 0) fs_cal_active = ~fs_cal_active;
         if ($urandom % 20 == 0) filt_ovf = 1'b1;
         if ($urandom % 60 == 0) lead_test_en = ~lead_test_en;
         if ($urandom % 8 == 0) begin
            res_vld = 1'b1;
            case ($urandom % 4)
               0: res_data = 24'h0;
               1: res_data = 24'hFFFFFF - 24'($urandom % 40);
               2: res_data = 24'($urandom);
               default: res_data = 24'h1;
            endcase
         end
         if ($urandom % 30 == 0) begin
            reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 24'($urandom);
         end else if ($urandom % 200 == 0) begin
            reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 24'($urandom);
         end else if ($urandom % 300 == 0) begin
            reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 24'($urandom % 64);
         end
         cyc();
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule